// File: doc/BRIEF.md
# Data-Strobe Link Character Transmitter

This block drives the outgoing half of a point-to-point serial link that uses a data line and a strobe line. On each character boundary a small scheduler picks what to send next: a pending time code, a pending flow-control token (FCT), a normal character from the transmit queue, or a NULL filler. The chosen character, or two-character sequence, is turned into a bit frame. A parity bit is chained from the previous character. The frame is then shifted out one bit per clock. The strobe line toggles whenever the data bit repeats, so exactly one of the two lines changes per bit.

Normal characters are 8-bit data bytes or end-of-packet markers. They come from a first-word-fall-through queue: a 9-bit word is presented together with an empty flag, and the block takes a word by pulsing a read strobe. The queue is read in the same cycle that the serializer's last bit is on the line, so consecutive characters follow each other with no idle bit. Normal characters are only sent while the far end has granted credit. Each FCT received from the far end grants eight more characters. A grant that would push the credit past 56 raises a sticky error flag.

Top module: `dstx_link_tx`

## Requirements
- R1: A data character is 10 bits sent in this order: parity bit, flag bit 0, then data bits 0 through 7 (least significant first).
- R2: A control character is 4 bits sent in this order: parity bit, flag bit 1, then control-code bit 0, then bit 1. The codes are FCT=2'b00, EOP=2'b01, EEP=2'b10 and ESC=2'b11.
- R3: Each parity bit makes the count of ones odd across three things: the code or data bits of the previous character, this parity bit, and this flag bit. After reset, the previous bits count as all zero.
- R4: A NULL is an ESC control character followed at once by an FCT control character. A NULL is sent when en_nulls is high and nothing else is eligible.
- R5: A tick_in pulse latches time_val (6 bits) and time_flags (2 bits). It leaves one time code pending, which is sent when en_times is high. A time code is an ESC followed by a data character whose bits 5:0 carry the time value and bits 7:6 carry the flags.
- R6: Each transmitted bit changes exactly one of d_out and s_out. The lines hold their values while nothing is sent. Both lines are low after reset.
- R7: At a character boundary the priority is: time code first, then the FCT requested by fct_req (when en_fcts is high), then a normal character, then NULL.
- R8: A normal character is sent only when en_chars is high, q_empty is low and the credit is non-zero. The word is taken by a one-cycle q_rd pulse, and each character sent lowers the credit by one.
- R9: Each fct_rcvd pulse adds 8 to the credit. If the sum would exceed 56, credit_err is set instead, the credit is left unchanged, and credit_err stays high until reset.
- R10: A queue word with bit 8 clear is a data character carrying bits 7:0. With bit 8 set, it is an EOP marker when bit 0 is 0 and an EEP marker when bit 0 is 1.
- R11: Back-to-back characters are serialized with no idle cycle between them.
- R12: During and right after reset: d_out, s_out, q_rd and credit_err are low, and the credit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit is sent per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| en_nulls | input | 1 | Allows NULL fillers |
| en_fcts | input | 1 | Allows a requested FCT to be sent |
| en_chars | input | 1 | Allows normal characters |
| en_times | input | 1 | Allows a pending time code to be sent |
| tick_in | input | 1 | Pulse: latch time value and flags, mark a time code pending |
| time_val | input | 6 | Time value captured on tick_in |
| time_flags | input | 2 | Control flags captured on tick_in |
| fct_req | input | 1 | Pulse: mark one outgoing FCT pending |
| fct_rcvd | input | 1 | Pulse: an FCT arrived from the far end (credit +8) |
| q_data | input | 9 | Head word of the transmit queue |
| q_empty | input | 1 | Transmit queue holds no word |
| q_rd | output | 1 | Pulse: head word taken from the queue |
| d_out | output | 1 | Data line |
| s_out | output | 1 | Strobe line |
| credit_err | output | 1 | Sticky credit overflow flag |

## Verification
On every cycle the assertions check the line coding: a bit period moves exactly one line, and an idle cycle moves neither. They also check that the credit stays within its bound, that the queue is never read without credit, that the error flag never clears, and that a pending time code is dropped only when it is actually scheduled. Frame content depends on history: the parity chain, the field order, the queue word decoding, and the order chosen among several eligible characters. These can only be shown by the bench's scenarios. The bench decodes the line back into bits and compares them with frames it builds from the requirements. The same goes for the exact credit limits, which take counted sequences of reads and grants.

// File: rtl/dstx_pkg.sv
// Package: shared codes, kinds and frame builders for the data-strobe transmitter.
// Frames are built LSB-first: bit 0 is the first bit put on the line.
package dstx_pkg;

    localparam int FRAME_W = 14;                  // ESC + data character, the longest frame
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    localparam logic [1:0] CODE_FCT = 2'b00;
    localparam logic [1:0] CODE_EOP = 2'b01;
    localparam logic [1:0] CODE_EEP = 2'b10;
    localparam logic [1:0] CODE_ESC = 2'b11;

    typedef enum logic [2:0] {
        K_NONE,
        K_TIME,
        K_FCT,
        K_NCHAR,
        K_NULL
    } kind_t;

    // Control character: parity, flag=1, code LSB first; prev = parity of previous payload
    function automatic logic [3:0] ctrl_bits(input logic [1:0] code, input logic prev);
        return {code[1], code[0], 1'b1, ~(prev ^ 1'b1)};
    endfunction

    // Data character: parity, flag=0, data LSB first
    function automatic logic [9:0] data_bits(input logic [7:0] d, input logic prev);
        return {d, 1'b0, ~(prev ^ 1'b0)};
    endfunction

endpackage

// File: rtl/dstx_credit.sv
// Module: dstx_credit
// Tracks how many normal characters the far end currently permits.
// Assumes consume is raised only while credit_ok is high.
module dstx_credit #(
    parameter int CREDIT_MAX  = 56,
    parameter int CREDIT_STEP = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fct_rcvd,
    input  logic consume,
    output logic credit_ok,
    output logic credit_err
);
    localparam int CW = $clog2(CREDIT_MAX + CREDIT_STEP + 1);

    logic [CW-1:0] credit;
    logic [CW-1:0] grant_sum;
    logic          overflow;

    // Candidate credit after a grant, and whether that grant breaks the bound
    always_comb begin
        grant_sum = credit + CW'(CREDIT_STEP);
        overflow  = fct_rcvd && (grant_sum > CW'(CREDIT_MAX));
    end

    assign credit_ok = (credit != '0);

    // Credit register and sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit     <= '0;
            credit_err <= 1'b0;
        end else begin
            credit <= credit - CW'(consume)
                    + ((fct_rcvd && !overflow) ? CW'(CREDIT_STEP) : '0);
            if (overflow) begin
                credit_err <= 1'b1;
            end
        end
    end

    // R9
    credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        credit <= CW'(CREDIT_MAX));

    // R8
    no_read_without_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> credit != '0);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        credit_err |=> credit_err);

endmodule

// File: rtl/dstx_sched.sv
// Module: dstx_sched
// Holds pending time-code and FCT requests and the parity chain. At each free
// slot it picks the next frame by priority and builds its bits.
// Assumes q_data is valid whenever q_empty is low (first-word fall-through).
module dstx_sched
    import dstx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_nulls,
    input  logic               en_fcts,
    input  logic               en_chars,
    input  logic               en_times,
    input  logic               tick_in,
    input  logic [5:0]         time_val,
    input  logic [1:0]         time_flags,
    input  logic               fct_req,
    input  logic [8:0]         q_data,
    input  logic               q_empty,
    input  logic               credit_ok,
    input  logic               slot_free,
    output logic               load,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   frame_len,
    output logic               q_rd
);
    logic       pend_time;
    logic       pend_fct;
    logic [7:0] time_lat;
    logic       prev_par;
    logic       last_par;
    kind_t      pick;
    logic [1:0] mark_code;

    // Priority choice among eligible characters at a free slot
    always_comb begin
        pick = K_NONE;
        if (slot_free) begin
            if (en_times && pend_time)                  pick = K_TIME;
            else if (en_fcts && pend_fct)               pick = K_FCT;
            else if (en_chars && credit_ok && !q_empty) pick = K_NCHAR;
            else if (en_nulls)                          pick = K_NULL;
        end
    end

    // Frame bits, length and resulting payload parity for the chosen kind
    always_comb begin
        frame     = '0;
        frame_len = '0;
        last_par  = prev_par;
        mark_code = q_data[0] ? CODE_EEP : CODE_EOP;
        case (pick)
            K_TIME: begin
                frame     = {data_bits(time_lat, ^CODE_ESC), ctrl_bits(CODE_ESC, prev_par)};
                frame_len = LEN_W'(14);
                last_par  = ^time_lat;
            end
            K_FCT: begin
                frame     = FRAME_W'(ctrl_bits(CODE_FCT, prev_par));
                frame_len = LEN_W'(4);
                last_par  = ^CODE_FCT;
            end
            K_NCHAR: begin
                if (q_data[8]) begin
                    frame     = FRAME_W'(ctrl_bits(mark_code, prev_par));
                    frame_len = LEN_W'(4);
                    last_par  = ^mark_code;
                end else begin
                    frame     = FRAME_W'(data_bits(q_data[7:0], prev_par));
                    frame_len = LEN_W'(10);
                    last_par  = ^q_data[7:0];
                end
            end
            K_NULL: begin
                frame     = FRAME_W'({ctrl_bits(CODE_FCT, ^CODE_ESC), ctrl_bits(CODE_ESC, prev_par)});
                frame_len = LEN_W'(8);
                last_par  = ^CODE_FCT;
            end
            default: ;
        endcase
    end

    assign load = (pick != K_NONE);
    assign q_rd = (pick == K_NCHAR);

    // Pending requests, latched time value and parity chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_time <= 1'b0;
            pend_fct  <= 1'b0;
            time_lat  <= '0;
            prev_par  <= 1'b0;
        end else begin
            pend_time <= (pend_time && pick != K_TIME) || tick_in;
            pend_fct  <= (pend_fct && pick != K_FCT) || fct_req;
            if (tick_in) begin
                time_lat <= {time_flags, time_val};
            end
            if (load) begin
                prev_par <= last_par;
            end
        end
    end

    // R5
    time_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_time) |-> $past(pick == K_TIME));

    // R8
    rd_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_rd |-> !q_empty && en_chars);

endmodule

// File: rtl/dstx_ser.sv
// Module: dstx_ser
// Shifts a loaded frame out LSB first, one bit per clock, with data-strobe coding.
// Assumes load is raised only while slot_free is high.
module dstx_ser
    import dstx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [LEN_W-1:0]   frame_len,
    output logic               slot_free,
    output logic               d_out,
    output logic               s_out
);
    logic [FRAME_W-1:0] sreg;
    logic [LEN_W-1:0]   left;
    logic               next_bit;
    logic               shift;

    // Next bit comes from a fresh frame or from the shift register
    always_comb begin
        shift    = load || (left != '0);
        next_bit = load ? frame[0] : sreg[0];
    end

    assign slot_free = (left == '0);

    // Shift register, bit counter and the two line registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg  <= '0;
            left  <= '0;
            d_out <= 1'b0;
            s_out <= 1'b0;
        end else if (shift) begin
            d_out <= next_bit;
            s_out <= (next_bit == d_out) ? ~s_out : s_out;
            sreg  <= load ? (frame >> 1) : (sreg >> 1);
            left  <= load ? frame_len - LEN_W'(1) : left - LEN_W'(1);
        end
    end

    // R6
    one_line_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> $countones({d_out ^ $past(d_out), s_out ^ $past(s_out)}) == 1);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(d_out) && $stable(s_out));

    // R11
    load_on_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> left == '0);

endmodule

// File: rtl/dstx_link_tx.sv
// Module: dstx_link_tx (top)
// Data-strobe link character transmitter: scheduler, credit tracker and serializer.
// Assumes a first-word-fall-through transmit queue and one bit per clock.
module dstx_link_tx
    import dstx_pkg::*;
#(
    parameter int CREDIT_MAX  = 56,
    parameter int CREDIT_STEP = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_nulls,
    input  logic       en_fcts,
    input  logic       en_chars,
    input  logic       en_times,
    input  logic       tick_in,
    input  logic [5:0] time_val,
    input  logic [1:0] time_flags,
    input  logic       fct_req,
    input  logic       fct_rcvd,
    input  logic [8:0] q_data,
    input  logic       q_empty,
    output logic       q_rd,
    output logic       d_out,
    output logic       s_out,
    output logic       credit_err
);
    logic               credit_ok;
    logic               slot_free;
    logic               load;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   frame_len;

    dstx_credit #(
        .CREDIT_MAX  (CREDIT_MAX),
        .CREDIT_STEP (CREDIT_STEP)
    ) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .fct_rcvd   (fct_rcvd),
        .consume    (q_rd),
        .credit_ok  (credit_ok),
        .credit_err (credit_err)
    );

    dstx_sched u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_nulls   (en_nulls),
        .en_fcts    (en_fcts),
        .en_chars   (en_chars),
        .en_times   (en_times),
        .tick_in    (tick_in),
        .time_val   (time_val),
        .time_flags (time_flags),
        .fct_req    (fct_req),
        .q_data     (q_data),
        .q_empty    (q_empty),
        .credit_ok  (credit_ok),
        .slot_free  (slot_free),
        .load       (load),
        .frame      (frame),
        .frame_len  (frame_len),
        .q_rd       (q_rd)
    );

    dstx_ser u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .frame     (frame),
        .frame_len (frame_len),
        .slot_free (slot_free),
        .d_out     (d_out),
        .s_out     (s_out)
    );

endmodule

// File: tb/test_dstx_link_tx.sv
// Bench for dstx_link_tx: decodes the line back to bits and compares them with
// frames built from the requirements.
module test_dstx_link_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_nulls = 1'b0, en_fcts = 1'b0, en_chars = 1'b0, en_times = 1'b0;
    logic       tick_in = 1'b0, fct_req = 1'b0, fct_rcvd = 1'b0;
    logic [5:0] time_val = '0;
    logic [1:0] time_flags = '0;
    logic [8:0] q_data = '0;
    logic       q_empty = 1'b1;
    logic       q_rd, d_out, s_out, credit_err;

    always #2 clk = ~clk;  // 250 MHz

    dstx_link_tx i_dstx_link_tx (
        .clk(clk), .rst_n(rst_n), .en_nulls(en_nulls), .en_fcts(en_fcts),
        .en_chars(en_chars), .en_times(en_times), .tick_in(tick_in),
        .time_val(time_val), .time_flags(time_flags), .fct_req(fct_req),
        .fct_rcvd(fct_rcvd), .q_data(q_data), .q_empty(q_empty), .q_rd(q_rd),
        .d_out(d_out), .s_out(s_out), .credit_err(credit_err)
    );

    int  nchk = 0, nfail = 0, nrd = 0, cyc = 0, cap_n = 0, exp_n = 0, ds_bad = 0;
    bit  auto_feed = 1'b0, done = 1'b0;
    bit  cap_b [0:1023];
    int  cap_c [0:1023];
    bit  exp_b [0:1023];
    bit  par_m = 1'b0;
    logic pd = 1'b0, ps = 1'b0;

    // Table: kind[11:9] (0 FCT request, 1 queue word, 2 time tick), value[8:0]
    localparam logic [11:0] VEC [0:8] = '{
        {3'd0, 9'h000}, {3'd1, 9'h000}, {3'd1, 9'h0FF}, {3'd1, 9'h0A5},
        {3'd1, 9'h100}, {3'd1, 9'h101}, {3'd2, 9'h0BF}, {3'd1, 9'h05A},
        {3'd0, 9'h000}
    };

    // Queue model: takes the word on q_rd, optionally refills with the next value
    always @(posedge clk) begin
        if (q_rd) begin
            nrd <= nrd + 1;
            if (auto_feed) q_data <= q_data + 9'd1;
            else           q_empty <= 1'b1;
        end
    end

    // Line decoder: a bit is any cycle in which a line moved
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if ((d_out != pd) && (s_out != ps)) ds_bad = ds_bad + 1;
            if ((d_out != pd) || (s_out != ps)) begin
                cap_b[cap_n] = d_out;
                cap_c[cap_n] = cyc;
                cap_n = cap_n + 1;
            end
        end
        pd = d_out;
        ps = s_out;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push_bit(input bit b);
        exp_b[exp_n] = b;
        exp_n++;
    endtask

    // Expected control character (R2, R3)
    task automatic push_ctrl(input logic [1:0] code);
        push_bit(~(par_m ^ 1'b1));
        push_bit(1'b1);
        push_bit(code[0]);
        push_bit(code[1]);
        par_m = code[0] ^ code[1];
    endtask

    // Expected data character (R1, R3)
    task automatic push_data(input logic [7:0] d);
        push_bit(~(par_m ^ 1'b0));
        push_bit(1'b0);
        for (int i = 0; i < 8; i++) push_bit(d[i]);
        par_m = ^d;
    endtask

    task automatic check_bits(input string req, input bit exact);
        int mism = 0;
        if (exact) chk(cap_n == exp_n, req, "bit count", cap_n, exp_n);
        else       chk(cap_n >= exp_n, req, "bit count at least", cap_n, exp_n);
        for (int i = 0; i < exp_n; i++)
            if (i < cap_n && cap_b[i] != exp_b[i]) mism++;
        chk(mism == 0, req, "mismatched bits", mism, 0);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_fct_rcvd();
        @(negedge clk) fct_rcvd = 1'b1;
        @(negedge clk) fct_rcvd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en_nulls = 0; en_fcts = 0; en_chars = 0; en_times = 0;
        auto_feed = 0; q_empty = 1'b1;
        @(posedge clk);
        #1;
        cap_n = 0; exp_n = 0; par_m = 1'b0; nrd = 0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        wait_cyc(3);
        chk(d_out == 0, "R12", "d_out in reset", d_out, 0);
        chk(s_out == 0, "R12", "s_out in reset", s_out, 0);
        chk(q_rd == 0, "R12", "q_rd in reset", q_rd, 0);
        chk(credit_err == 0, "R12", "credit_err in reset", credit_err, 0);
        do_reset();
        chk(d_out == 0 && s_out == 0, "R6", "lines low after reset", {d_out, s_out}, 0);

        // R8: no credit, word waiting -> nothing read or sent
        en_chars = 1'b1; q_data = 9'h0C3; q_empty = 1'b0;
        wait_cyc(20);
        chk(nrd == 0, "R8", "reads with zero credit", nrd, 0);
        chk(cap_n == 0, "R8", "bits with zero credit (R6 idle hold)", cap_n, 0);
        pulse_fct_rcvd();
        push_data(8'hC3);
        wait_cyc(25);
        check_bits("R8 R1", 1);
        chk(nrd == 1, "R8", "reads after one grant", nrd, 1);

        // Table: one character per entry (R1 R2 R3 R5 R10)
        en_fcts = 1'b1; en_times = 1'b1;
        for (int v = 0; v < 9; v++) begin
            @(negedge clk);
            case (VEC[v][11:9])
                3'd0: begin
                    fct_req = 1'b1;
                    push_ctrl(2'b00);
                    @(negedge clk) fct_req = 1'b0;
                end
                3'd1: begin
                    q_data = VEC[v][8:0];
                    q_empty = 1'b0;
                    if (VEC[v][8]) push_ctrl(VEC[v][0] ? 2'b10 : 2'b01);
                    else           push_data(VEC[v][7:0]);
                end
                default: begin
                    time_val = VEC[v][5:0];
                    time_flags = VEC[v][7:6];
                    tick_in = 1'b1;
                    push_ctrl(2'b11);
                    push_data(VEC[v][7:0]);
                    @(negedge clk) tick_in = 1'b0;
                end
            endcase
            wait_cyc(25);
            check_bits("R1 R2 R3 R5 R10", 1);
        end

        // R8 R11: one grant, endless queue -> exactly 8 characters, back to back
        do_reset();
        en_chars = 1'b1; q_data = 9'h000; q_empty = 1'b0; auto_feed = 1'b1;
        for (int k = 0; k < 8; k++) push_data(8'(k));
        pulse_fct_rcvd();
        wait_cyc(120);
        chk(nrd == 8, "R8", "reads for one grant", nrd, 8);
        check_bits("R8 R1 R3", 1);
        chk(cap_n == 80 && cap_c[79] - cap_c[0] == 79, "R11", "span of 80 bits",
            cap_c[79] - cap_c[0], 79);

        // R7 R4: time, FCT, normal and NULL all eligible at once
        do_reset();
        pulse_fct_rcvd();
        q_data = 9'h033; q_empty = 1'b0;
        time_val = 6'h15; time_flags = 2'b10;
        @(negedge clk);
        tick_in = 1'b1; fct_req = 1'b1;
        @(negedge clk);
        tick_in = 1'b0; fct_req = 1'b0;
        @(negedge clk);
        chk(cap_n == 0 && nrd == 0, "R7", "nothing sent while disabled", cap_n, 0);
        en_times = 1'b1; en_fcts = 1'b1; en_chars = 1'b1; en_nulls = 1'b1;
        push_ctrl(2'b11); push_data({2'b10, 6'h15});
        push_ctrl(2'b00);
        push_data(8'h33);
        push_ctrl(2'b11); push_ctrl(2'b00);
        wait_cyc(31);
        en_nulls = 1'b0;
        wait_cyc(20);
        check_bits("R7 R4 R5", 0);

        // R9: overflow sets sticky error, credit stays at 56
        do_reset();
        for (int k = 0; k < 7; k++) pulse_fct_rcvd();
        wait_cyc(2);
        chk(credit_err == 0, "R9", "error after 7 grants", credit_err, 0);
        pulse_fct_rcvd();
        wait_cyc(2);
        chk(credit_err == 1, "R9", "error after 8th grant", credit_err, 1);
        wait_cyc(10);
        chk(credit_err == 1, "R9", "error still held", credit_err, 1);
        en_chars = 1'b1; q_data = 9'h000; q_empty = 1'b0; auto_feed = 1'b1;
        wait_cyc(700);
        chk(nrd == 56, "R9", "characters sent on capped credit", nrd, 56);

        chk(ds_bad == 0, "R6", "bits moving both lines", ds_bad, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule